// File: doc/BRIEF.md
# AUX Request Engine with Byte Register Front End

This block lets a host build one AUX-style request through a small set of byte-wide registers, launch it, and collect the reply. The host writes a 20-bit target address across three registers, with the request command in the upper nibble of the top address byte. It also writes a length/flags byte, pushes write payload bytes into an internal FIFO, and sets a self-clearing send bit. The engine hands the request to an abstract link-side interface: a valid/ready request carrying command, address, length and payload, followed by a one-cycle reply carrying a 3-bit status code, a byte count and read data.

When the reply arrives, or when the link stays silent past a parameterised limit, the engine posts a packed status byte. For read commands it loads the returned bytes into a read FIFO, which the host drains one byte per read of a data register. A channel-reset write clears both FIFOs and the status before the next request. Line signalling and coding are outside this block; the link side is abstract.

Top module: `aux_req_engine`

## Requirements
- R1: Offsets 0x7d, 0x7e and 0x7f hold address bytes low first. The request address is {byte 0x7f bits 3:0, byte 0x7e, byte 0x7d}, and the request command is byte 0x7f bits 7:4. These three registers and 0x80 read back exactly what was written.
- R2: Offset 0x80 bits 3:0 hold the payload length minus one, and bit 7 marks a request with no payload. The request length is 0 when bit 7 is set, otherwise bits 3:0 plus one (1 to 16).
- R3: Each write to offset 0x81 pushes one byte into the write FIFO, which holds 16 bytes; further pushes are dropped. Request payload byte i (bits 8i+7:8i) is the i-th pushed byte, or 0x00 where fewer were pushed. The write FIFO empties when the request launches.
- R4: Writing a value with bit 0 = 1 to offset 0x83 launches a request, and bit 0 of 0x83 reads 1 from the next cycle until the result is posted. A send written while a request is in progress has no effect and produces no second request.
- R5: Offset 0x84 reads {code[2:0], M[4:0]}, with codes 1 native NACK, 2 native DEFER, 3 ACK, 4 invalid, 5 I2C NACK, 6 I2C DEFER, 7 timeout. M is the link's count clamped to 16 for codes 2, 3 and 6, and 0 for every other code.
- R6: For read commands (command bit 0 = 1) with code 2, 3 or 6, the first M reply bytes can be popped in order (byte 0 = bits 7:0) through offset 0x82. After any other completion the read FIFO is empty.
- R7: Each read of offset 0x82 pops one byte. Reading it while the read FIFO is empty returns 0x00.
- R8: If no reply arrives within TIMEOUT_CYC cycles of launch, the request finishes with status 0xE0 (code 7, M = 0) and the send bit clears.
- R9: Writing 0xff to offset 0x76 empties both FIFOs and clears the status to 0x00. Any other value written there has no effect.
- R10: After reset, status and send bit read 0, all address and length registers read 0, and no request is presented.
- R11: While a request is valid and not yet accepted, command, address and length stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_re | input | 1 | Host register read strobe (pops at 0x82) |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| lnk_req_valid | output | 1 | Request presented to the link |
| lnk_req_ready | input | 1 | Link accepts the request |
| lnk_req_cmd | output | 4 | Request command nibble |
| lnk_req_addr | output | 20 | Target address |
| lnk_req_len | output | $clog2(DEPTH+1) | Payload length in bytes |
| lnk_req_data | output | DEPTH*8 | Payload, byte 0 in bits 7:0 |
| lnk_rsp_valid | input | 1 | One-cycle reply strobe |
| lnk_rsp_status | input | 3 | Reply code |
| lnk_rsp_count | input | 5 | Reply byte count |
| lnk_rsp_data | input | DEPTH*8 | Reply data, byte 0 in bits 7:0 |

## Verification
The assertions assume that the link raises its reply strobe only after accepting a request, and that the host performs at most one register access per cycle. The behavioural link model in the bench replies only after a completed handshake, with randomised accept and reply delays far below the timeout. The bench drives every register access from a single task, so a read and a write never coincide. The timeout case uses a silent link mode.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;

    // Register offsets (host decodes these)
    localparam logic [7:0] OFS_CHAN_CFG = 8'h76;
    localparam logic [7:0] OFS_ADDR0    = 8'h7d;
    localparam logic [7:0] OFS_ADDR1    = 8'h7e;
    localparam logic [7:0] OFS_ADDR2    = 8'h7f;
    localparam logic [7:0] OFS_LEN      = 8'h80;
    localparam logic [7:0] OFS_WDATA    = 8'h81;
    localparam logic [7:0] OFS_RDATA    = 8'h82;
    localparam logic [7:0] OFS_CTRL     = 8'h83;
    localparam logic [7:0] OFS_STATUS   = 8'h84;

    localparam logic [7:0] CHAN_RESET_KEY = 8'hff;

    // Reply codes
    localparam logic [2:0] RSP_NONE      = 3'd0;
    localparam logic [2:0] RSP_NACK      = 3'd1;
    localparam logic [2:0] RSP_DEFER     = 3'd2;
    localparam logic [2:0] RSP_ACK       = 3'd3;
    localparam logic [2:0] RSP_INVALID   = 3'd4;
    localparam logic [2:0] RSP_I2C_NACK  = 3'd5;
    localparam logic [2:0] RSP_I2C_DEFER = 3'd6;
    localparam logic [2:0] RSP_TIMEOUT   = 3'd7;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REQ  = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_e;

    // Codes whose byte count is meaningful
    function automatic logic code_has_count(input logic [2:0] code);
        return (code == RSP_DEFER) || (code == RSP_ACK) || (code == RSP_I2C_DEFER);
    endfunction

endpackage

// File: rtl/aux_byte_fifo.sv
module aux_byte_fifo #(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 push,
    input  logic [7:0]           push_data,
    input  logic                 pop,
    input  logic                 load,
    input  logic [DEPTH*8-1:0]   load_data,
    input  logic [CW-1:0]        load_count,
    output logic [7:0]           head,
    output logic [CW-1:0]        count,
    output logic [DEPTH*8-1:0]   flat
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [CW-1:0]         cnt;
    } fifo_s;

    fifo_s d, q;

    // Entry 0 is always the head; a pop shifts toward it.
    always_comb begin
        d = q;
        if (clr) begin
            d.cnt = '0;
        end else if (load) begin
            d.mem = load_data;
            d.cnt = load_count;
        end else if (pop && (q.cnt != '0)) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                d.mem[i] = q.mem[i+1];
            end
            d.mem[DEPTH-1] = '0;
            d.cnt = q.cnt - CW'(1);
        end else if (push && (q.cnt < CW'(DEPTH))) begin
            d.mem[q.cnt[AW-1:0]] = push_data;
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign count = q.cnt;
    assign head  = (q.cnt != '0) ? q.mem[0] : 8'h00;

    // Entries beyond the fill level read as zero.
    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign flat[g*8 +: 8] = (CW'(g) < q.cnt) ? q.mem[g] : 8'h00;
    end

endmodule

// File: rtl/aux_link_seq.sv
module aux_link_seq
    import aux_req_pkg::*;
#(
    parameter  int DEPTH       = 16,
    parameter  int TIMEOUT_CYC = 500,
    localparam int CW          = $clog2(DEPTH + 1),
    localparam int TW          = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [3:0]           start_cmd,
    input  logic [19:0]          start_addr,
    input  logic [CW-1:0]        start_len,
    input  logic [DEPTH*8-1:0]   start_data,
    output logic                 lnk_req_valid,
    input  logic                 lnk_req_ready,
    output logic [3:0]           lnk_req_cmd,
    output logic [19:0]          lnk_req_addr,
    output logic [CW-1:0]        lnk_req_len,
    output logic [DEPTH*8-1:0]   lnk_req_data,
    input  logic                 lnk_rsp_valid,
    input  logic [2:0]           lnk_rsp_status,
    input  logic [4:0]           lnk_rsp_count,
    input  logic [DEPTH*8-1:0]   lnk_rsp_data,
    output logic                 busy,
    output logic                 done,
    output logic [2:0]           done_code,
    output logic [4:0]           done_m,
    output logic [CW-1:0]        done_rd_count,
    output logic [DEPTH*8-1:0]   done_rd_data
);

    localparam logic [TW-1:0] TMR_LIM = TW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        seq_state_e            st;
        logic [3:0]            cmd;
        logic [19:0]           addr;
        logic [CW-1:0]         len;
        logic [DEPTH*8-1:0]    data;
        logic [TW-1:0]         tmr;
        logic                  done;
        logic [2:0]            code;
        logic [4:0]            m;
        logic [CW-1:0]         rdn;
        logic [DEPTH*8-1:0]    rdata;
    } seq_s;

    seq_s d, q;
    logic [4:0] cnt_clamped;

    assign cnt_clamped = (lnk_rsp_count > 5'(DEPTH)) ? 5'(DEPTH) : lnk_rsp_count;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            SEQ_IDLE: begin
                if (start && !q.done) begin
                    d.st   = SEQ_REQ;
                    d.cmd  = start_cmd;
                    d.addr = start_addr;
                    d.len  = start_len;
                    d.data = start_data;
                    d.tmr  = '0;
                end
            end
            SEQ_REQ, SEQ_WAIT: begin
                d.tmr = q.tmr + TW'(1);
                if (q.st == SEQ_WAIT && lnk_rsp_valid) begin
                    d.st    = SEQ_IDLE;
                    d.done  = 1'b1;
                    d.code  = lnk_rsp_status;
                    d.m     = code_has_count(lnk_rsp_status) ? cnt_clamped : 5'd0;
                    d.rdn   = (q.cmd[0] && code_has_count(lnk_rsp_status))
                              ? CW'(cnt_clamped) : '0;
                    d.rdata = lnk_rsp_data;
                end else if (q.st == SEQ_REQ && lnk_req_ready) begin
                    d.st = SEQ_WAIT;
                end else if (q.tmr >= TMR_LIM) begin
                    d.st   = SEQ_IDLE;
                    d.done = 1'b1;
                    d.code = RSP_TIMEOUT;
                    d.m    = 5'd0;
                    d.rdn  = '0;
                end
            end
            default: d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign lnk_req_valid = (q.st == SEQ_REQ);
    assign lnk_req_cmd   = q.cmd;
    assign lnk_req_addr  = q.addr;
    assign lnk_req_len   = q.len;
    assign lnk_req_data  = q.data;
    // Busy covers the posting cycle so status is valid once busy drops.
    assign busy          = (q.st != SEQ_IDLE) || q.done;
    assign done          = q.done;
    assign done_code     = q.code;
    assign done_m        = q.m;
    assign done_rd_count = q.rdn;
    assign done_rd_data  = q.rdata;

endmodule

// File: rtl/aux_req_engine.sv
module aux_req_engine
    import aux_req_pkg::*;
#(
    parameter  int DEPTH       = 16,
    parameter  int TIMEOUT_CYC = 500,
    localparam int CW          = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic                 reg_re,
    input  logic [7:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    output logic                 lnk_req_valid,
    input  logic                 lnk_req_ready,
    output logic [3:0]           lnk_req_cmd,
    output logic [19:0]          lnk_req_addr,
    output logic [CW-1:0]        lnk_req_len,
    output logic [DEPTH*8-1:0]   lnk_req_data,
    input  logic                 lnk_rsp_valid,
    input  logic [2:0]           lnk_rsp_status,
    input  logic [4:0]           lnk_rsp_count,
    input  logic [DEPTH*8-1:0]   lnk_rsp_data
);

    typedef struct packed {
        logic [7:0] a0;
        logic [7:0] a1;
        logic [7:0] a2;
        logic [7:0] lenb;
        logic [7:0] status;
    } regs_s;

    regs_s d, q;

    logic               chan_rst, launch, push, pop;
    logic               seq_busy, seq_done;
    logic [2:0]         seq_code;
    logic [4:0]         seq_m;
    logic [CW-1:0]      seq_rdn;
    logic [DEPTH*8-1:0] seq_rdata;
    logic [7:0]         wf_head, rf_head;
    logic [CW-1:0]      wf_count, rf_count;
    logic [DEPTH*8-1:0] wf_flat, rf_flat;
    logic [CW-1:0]      req_len;
    logic [CW:0]        len_plus;
    logic [7:0]         status_q;

    assign chan_rst = reg_we && (reg_addr == OFS_CHAN_CFG) && (reg_wdata == CHAN_RESET_KEY);
    assign launch   = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[0] && !seq_busy;
    assign push     = reg_we && (reg_addr == OFS_WDATA);
    assign pop      = reg_re && (reg_addr == OFS_RDATA);

    // Length field holds count minus one; clamp to the FIFO depth.
    assign len_plus = (CW+1)'(q.lenb[3:0]) + (CW+1)'(1);
    always_comb begin
        if (q.lenb[7]) begin
            req_len = '0;
        end else if (len_plus > (CW+1)'(DEPTH)) begin
            req_len = CW'(DEPTH);
        end else begin
            req_len = len_plus[CW-1:0];
        end
    end

    always_comb begin
        d = q;
        if (reg_we) begin
            unique case (reg_addr)
                OFS_ADDR0: d.a0   = reg_wdata;
                OFS_ADDR1: d.a1   = reg_wdata;
                OFS_ADDR2: d.a2   = reg_wdata;
                OFS_LEN:   d.lenb = reg_wdata;
                default: ;
            endcase
        end
        if (chan_rst) begin
            d.status = 8'h00;
        end else if (seq_done) begin
            d.status = {seq_code, seq_m};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign status_q = q.status;

    always_comb begin
        unique case (reg_addr)
            OFS_ADDR0:  reg_rdata = q.a0;
            OFS_ADDR1:  reg_rdata = q.a1;
            OFS_ADDR2:  reg_rdata = q.a2;
            OFS_LEN:    reg_rdata = q.lenb;
            OFS_RDATA:  reg_rdata = rf_head;
            OFS_CTRL:   reg_rdata = {7'b0, seq_busy};
            OFS_STATUS: reg_rdata = q.status;
            default:    reg_rdata = 8'h00;
        endcase
    end

    aux_byte_fifo #(.DEPTH(DEPTH)) u_wfifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (chan_rst || launch),
        .push       (push),
        .push_data  (reg_wdata),
        .pop        (1'b0),
        .load       (1'b0),
        .load_data  ('0),
        .load_count ('0),
        .head       (wf_head),
        .count      (wf_count),
        .flat       (wf_flat)
    );

    aux_byte_fifo #(.DEPTH(DEPTH)) u_rfifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (chan_rst),
        .push       (1'b0),
        .push_data  (8'h00),
        .pop        (pop),
        .load       (seq_done),
        .load_data  (seq_rdata),
        .load_count (seq_rdn),
        .head       (rf_head),
        .count      (rf_count),
        .flat       (rf_flat)
    );

    aux_link_seq #(.DEPTH(DEPTH), .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (launch),
        .start_cmd      (q.a2[7:4]),
        .start_addr     ({q.a2[3:0], q.a1, q.a0}),
        .start_len      (req_len),
        .start_data     (wf_flat),
        .lnk_req_valid  (lnk_req_valid),
        .lnk_req_ready  (lnk_req_ready),
        .lnk_req_cmd    (lnk_req_cmd),
        .lnk_req_addr   (lnk_req_addr),
        .lnk_req_len    (lnk_req_len),
        .lnk_req_data   (lnk_req_data),
        .lnk_rsp_valid  (lnk_rsp_valid),
        .lnk_rsp_status (lnk_rsp_status),
        .lnk_rsp_count  (lnk_rsp_count),
        .lnk_rsp_data   (lnk_rsp_data),
        .busy           (seq_busy),
        .done           (seq_done),
        .done_code      (seq_code),
        .done_m         (seq_m),
        .done_rd_count  (seq_rdn),
        .done_rd_data   (seq_rdata)
    );

endmodule

// File: rtl/aux_req_engine_chk.sv
module aux_req_engine_chk
    import aux_req_pkg::*;
#(
    parameter  int DEPTH       = 16,
    parameter  int TIMEOUT_CYC = 500,
    localparam int CW          = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [7:0]    reg_addr,
    input logic [7:0]    reg_wdata,
    input logic          lnk_req_valid,
    input logic          lnk_req_ready,
    input logic [3:0]    lnk_req_cmd,
    input logic [19:0]   lnk_req_addr,
    input logic [CW-1:0] lnk_req_len,
    input logic          busy,
    input logic [CW-1:0] wcount,
    input logic [CW-1:0] rcount,
    input logic [7:0]    status
);

    logic [31:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 32'd1;
        end else begin
            busy_run <= '0;
        end
    end

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_req_valid && !lnk_req_ready |=> lnk_req_valid && $stable(lnk_req_cmd)
            && $stable(lnk_req_addr) && $stable(lnk_req_len));

    p_len_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_req_valid |-> lnk_req_len <= CW'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wcount <= CW'(DEPTH)) && (rcount <= CW'(DEPTH)));

    p_valid_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_req_valid |-> busy);

    p_count_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !code_has_count(status[7:5]) |-> status[4:0] == 5'd0);

    p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 32'(TIMEOUT_CYC + 1));

    p_chan_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && (reg_addr == OFS_CHAN_CFG) && (reg_wdata == CHAN_RESET_KEY)
            |=> (wcount == '0) && (rcount == '0) && (status == 8'h00));

endmodule

bind aux_req_engine aux_req_engine_chk #(.DEPTH(DEPTH), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .lnk_req_valid (lnk_req_valid),
    .lnk_req_ready (lnk_req_ready),
    .lnk_req_cmd   (lnk_req_cmd),
    .lnk_req_addr  (lnk_req_addr),
    .lnk_req_len   (lnk_req_len),
    .busy          (seq_busy),
    .wcount        (wf_count),
    .rcount        (rf_count),
    .status        (status_q)
);

// File: tb/tb_aux_req_engine.sv
`timescale 1ns/1ps
module tb_aux_req_engine;
    import aux_req_pkg::*;

    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic               reg_we = 1'b0, reg_re = 1'b0;
    logic [7:0]         reg_addr = 8'h00, reg_wdata = 8'h00;
    logic [7:0]         reg_rdata;
    logic               lnk_req_valid;
    logic               lnk_req_ready = 1'b0;
    logic [3:0]         lnk_req_cmd;
    logic [19:0]        lnk_req_addr;
    logic [CW-1:0]      lnk_req_len;
    logic [DEPTH*8-1:0] lnk_req_data;
    logic               lnk_rsp_valid = 1'b0;
    logic [2:0]         lnk_rsp_status = 3'd0;
    logic [4:0]         lnk_rsp_count = 5'd0;
    logic [DEPTH*8-1:0] lnk_rsp_data = '0;

    aux_req_engine dut (.*);

    int checks = 0;
    int fails  = 0;

    // Link model controls and captures
    int                 mdl_rdy_dly = 0, mdl_rsp_dly = 0;
    bit                 mdl_silent = 1'b0;
    logic [2:0]         mdl_code = 3'd3;
    logic [4:0]         mdl_cnt = 5'd0;
    logic [DEPTH*8-1:0] mdl_data = '0;
    logic [3:0]         cap_cmd;
    logic [19:0]        cap_addr;
    logic [CW-1:0]      cap_len;
    logic [DEPTH*8-1:0] cap_data;
    int                 seen_req = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (lnk_req_valid) begin
                repeat (mdl_rdy_dly) @(negedge clk);
                cap_cmd  = lnk_req_cmd;
                cap_addr = lnk_req_addr;
                cap_len  = lnk_req_len;
                cap_data = lnk_req_data;
                lnk_req_ready = 1'b1;
                @(negedge clk);
                lnk_req_ready = 1'b0;
                seen_req++;
                if (!mdl_silent) begin
                    repeat (mdl_rsp_dly) @(negedge clk);
                    lnk_rsp_valid  = 1'b1;
                    lnk_rsp_status = mdl_code;
                    lnk_rsp_count  = mdl_cnt;
                    lnk_rsp_data   = mdl_data;
                    @(negedge clk);
                    lnk_rsp_valid  = 1'b0;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        reg_re = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(OFS_CTRL, v);
            if (!v[0]) break;
        end
    endtask

    function automatic int exp_m(input logic [2:0] code, input logic [4:0] cnt);
        if (!code_has_count(code)) return 0;
        return (cnt > 5'd16) ? 16 : int'(cnt);
    endfunction

    task automatic xfer(input logic [3:0] cmd, input logic [19:0] addr, input bit nopay,
                        input logic [3:0] lenm1, input int npush,
                        input logic [2:0] code, input logic [4:0] cnt);
        logic [7:0]   pushed [32];
        logic [127:0] expd;
        logic [7:0]   v;
        int           m, nrd, s0;
        wr(OFS_CHAN_CFG, 8'hff);
        wr(OFS_ADDR0, addr[7:0]);
        wr(OFS_ADDR1, addr[15:8]);
        wr(OFS_ADDR2, {cmd, addr[19:16]});
        wr(OFS_LEN, {nopay, 3'b000, lenm1});
        rd(OFS_ADDR0, v); check("R1 addr0 readback", v, addr[7:0]);
        rd(OFS_ADDR2, v); check("R1 addr2 readback", v, {cmd, addr[19:16]});
        rd(OFS_LEN, v);   check("R1 len readback", v, {nopay, 3'b000, lenm1});
        for (int i = 0; i < npush; i++) begin
            pushed[i] = 8'($urandom);
            wr(OFS_WDATA, pushed[i]);
        end
        expd = '0;
        for (int i = 0; i < 16; i++) begin
            if (i < npush) expd[i*8 +: 8] = pushed[i];
        end
        mdl_code = code; mdl_cnt = cnt;
        mdl_data = {$urandom, $urandom, $urandom, $urandom};
        mdl_rdy_dly = $urandom_range(0, 5);
        mdl_rsp_dly = $urandom_range(0, 20);
        s0 = seen_req;
        wr(OFS_CTRL, 8'h01);
        rd(OFS_CTRL, v); check("R4 send bit set", v, 8'h01);
        wait_idle();
        check("R4 one request", 128'(seen_req - s0), 128'd1);
        check("R1 cmd", cap_cmd, cmd);
        check("R1 addr", cap_addr, addr);
        check("R2 len", cap_len, nopay ? 0 : int'(lenm1) + 1);
        check("R3 payload", cap_data, expd);
        m = exp_m(code, cnt);
        nrd = cmd[0] ? m : 0;
        rd(OFS_STATUS, v); check("R5 status", v, {code, 5'(m)});
        for (int i = 0; i < nrd; i++) begin
            rd(OFS_RDATA, v); check("R6 read byte", v, mdl_data[i*8 +: 8]);
        end
        rd(OFS_RDATA, v); check("R7 empty pop", v, 8'h00);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic [3:0] cmds [4];
        int s0;
        cmds[0] = 4'h8; cmds[1] = 4'h9; cmds[2] = 4'h0; cmds[3] = 4'h1;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 req valid", lnk_req_valid, 1'b0);
        rd(OFS_STATUS, v); check("R10 status", v, 8'h00);
        rd(OFS_CTRL, v);   check("R10 ctrl", v, 8'h00);
        rd(OFS_ADDR1, v);  check("R10 addr1", v, 8'h00);
        rd(OFS_RDATA, v);  check("R7 pop after reset", v, 8'h00);

        // Directed: full payload plus dropped overflow pushes (R3)
        xfer(4'h8, 20'hABCDE, 1'b0, 4'hF, 18, RSP_ACK, 5'd0);
        // Directed: address-only read (R2), count clamp (R5, R6)
        xfer(4'h9, 20'h00001, 1'b1, 4'h3, 0, RSP_ACK, 5'd20);
        // Directed: I2C defer read, partial count
        xfer(4'h1, 20'hFFFFF, 1'b0, 4'h7, 0, RSP_I2C_DEFER, 5'd5);
        // Directed: read with NACK delivers nothing (R6)
        xfer(4'h9, 20'h12345, 1'b0, 4'h3, 0, RSP_NACK, 5'd9);

        // Random mix
        for (int n = 0; n < 40; n++) begin
            logic [3:0] c;
            bit np;
            logic [3:0] lm;
            c  = cmds[$urandom_range(0, 3)];
            np = ($urandom_range(0, 9) == 0);
            lm = 4'($urandom_range(0, 15));
            xfer(c, 20'($urandom), np, lm, (!c[0] && !np) ? int'(lm) + 1 : 0,
                 3'($urandom_range(1, 7)), 5'($urandom_range(0, 20)));
        end

        // R4: send while busy is ignored
        wr(OFS_CHAN_CFG, 8'hff);
        wr(OFS_LEN, 8'h00);
        mdl_silent = 1'b0; mdl_rdy_dly = 2; mdl_rsp_dly = 15; mdl_code = RSP_ACK; mdl_cnt = 5'd1;
        s0 = seen_req;
        wr(OFS_CTRL, 8'h01);
        wr(OFS_CTRL, 8'h01);
        wr(OFS_CTRL, 8'h01);
        wait_idle();
        repeat (40) @(negedge clk);
        check("R4 busy send ignored", 128'(seen_req - s0), 128'd1);

        // R8: timeout with a silent link
        mdl_silent = 1'b1; mdl_rdy_dly = 0;
        wr(OFS_CTRL, 8'h01);
        repeat (100) @(negedge clk);
        rd(OFS_CTRL, v); check("R8 still busy", v, 8'h01);
        wait_idle();
        rd(OFS_STATUS, v); check("R8 timeout status", v, 8'hE0);
        mdl_silent = 1'b0;

        // R9: channel reset
        wr(OFS_ADDR2, 8'h90);
        wr(OFS_LEN, 8'h03);
        mdl_code = RSP_ACK; mdl_cnt = 5'd4; mdl_data = 128'h0102030405060708090A0B0C0D0E0F10;
        mdl_rsp_dly = 3;
        wr(OFS_CTRL, 8'h01);
        wait_idle();
        wr(OFS_WDATA, 8'h5A); wr(OFS_WDATA, 8'hA5); wr(OFS_WDATA, 8'h3C);
        wr(OFS_CHAN_CFG, 8'h55);
        rd(OFS_STATUS, v); check("R9 other value no effect", v, 8'h64);
        wr(OFS_CHAN_CFG, 8'hff);
        rd(OFS_STATUS, v); check("R9 status cleared", v, 8'h00);
        rd(OFS_RDATA, v);  check("R9 read fifo empty", v, 8'h00);
        wr(OFS_ADDR2, 8'h80);
        wr(OFS_LEN, 8'h02);
        wr(OFS_CTRL, 8'h01);
        wait_idle();
        check("R9 write fifo empty", cap_data, 128'd0);
        check("R9 len", cap_len, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule